// File: doc/BRIEF.md
# Indexed-Write Command Packer

The packer turns a stream of register-write requests into a command buffer for a downstream register-programming engine. Each request carries a 20-bit register offset, a 32-bit value and a 32-bit bit mask. The packer writes two-word instructions into a local word-addressed memory through a single write port. When a full-word write targets the same register as the instruction just emitted, the packer does not emit a new instruction. It rewrites the earlier one in place as a counted indexed write and appends the new value to it, keeping the count word current and padding odd lengths with a zero word.

Besides register writes, the packer emits no-op, microsecond-wait, frame-wait and interrupt instructions. A finish request zero-fills the buffer up to the next 64-byte boundary and reports the final tail in bytes. A request that would not fit is dropped and flagged. A synchronous clear returns the write pointer, the instruction start and the saved copy of the last instruction to zero, so a new buffer can be built.

The controller is a single state machine. **IDLE** (`req_ready` high) accepts a request and picks one of the following paths:
- Drop on overflow: stay in IDLE.
- Fresh instruction: EMIT_LO → EMIT_HI → IDLE.
- Conversion of a single write: CONV_HDR → CONV_MOVE → APPEND.
- Append to an indexed write: APPEND → COUNT, then → PAD → IDLE when the pointer is odd, or → IDLE when it is even.
- Finish: FILL (repeated until the pointer reaches a line boundary) → DONE → IDLE. When the pointer is already aligned, IDLE goes directly to DONE.

Clear forces IDLE from any state.

Top module: `cmdbuf_packer`

## Requirements
- R1: Every new instruction starts at an even word index: the pointer is rounded up to even before the first word is written.
- R2: A register write is stored as word0 = value and word1 = {opcode 8'h01 in [31:24], byte enables in [23:20], offset in [19:0]}, and the pointer then advances to the start plus 2.
- R3: A full-mask write to the same offset as a previous single full-mask write converts that instruction in place. The header becomes {8'h09, 4'h0, offset}, the earlier value moves to start+2, and the pointer becomes start+3 before the new value is appended.
- R4: Each appended value is written at the pointer, the pointer increments, and the count in word0 of the instruction is incremented and rewritten. A converted instruction holding two values has a count of 2.
- R5: If the pointer is odd after an append, a zero word is written at the pointer, and the pointer stays where it is.
- R6: Byte-enable bit i is set when any bit of mask byte i (bits 8i+7..8i) is set. A write whose enables are not all four set is never merged, and a later write to the same offset starts a fresh instruction.
- R7: A non-finish request arriving when the pointer exceeds capacity minus 2 words raises `overflow` for that cycle. The request is dropped with no memory write.
- R8: Finish writes zeros from the pointer up to the next multiple of 16 words, then pulses `tail_valid` with `tail_bytes` = pointer × 4. When the pointer is already aligned, no word is written.
- R9: With the pointer at zero, no merge is attempted, whatever the memory holds.
- R10: Other instructions use word1 = {opcode, 24'h0}. A no-op is opcode 8'h00 with word0 = 0. A microsecond wait is opcode 8'h02 and a frame wait is opcode 8'h04, each with word0 = value. An interrupt is opcode 8'h07 with word0 = 0.
- R11: `clr` returns the pointer, the instruction start and the saved instruction copy to zero, so the next write is never merged with one made before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of pointer, start and saved instruction |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer in IDLE, request accepted this cycle |
| req_kind | input | 3 | 0 write, 1 no-op, 2 microsecond wait, 3 frame wait, 4 interrupt, 5 finish; other codes act as a no-op |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Value or wait count |
| req_mask | input | 32 | Bit mask converted to byte enables |
| overflow | output | 1 | Request dropped for lack of room |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 6 | Buffer word index |
| mem_wdata | output | 32 | Buffer write data |
| tail_valid | output | 1 | One-cycle pulse at the end of finish |
| tail_bytes | output | 9 | Final tail in bytes |

## Verification
On every cycle, the assertions check a set of local ordering and bound properties:
- the pointer is even after a fresh instruction;
- a conversion moves the old value to start+2;
- an append is followed by the count rewrite at the instruction start;
- an odd pointer after an append gets a zero pad;
- a dropped request never writes;
- the pointer stays within capacity;
- every reported tail is line aligned.

Only the bench scenarios can show the merged buffer contents: headers, counts, moved values, no-merge after a partial mask or a clear, zero fill over stale memory, and the exact tail values.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int OFF_W = 20;

    localparam logic [7:0] OP_NOOP       = 8'h00;
    localparam logic [7:0] OP_WRITE      = 8'h01;
    localparam logic [7:0] OP_WAIT_US    = 8'h02;
    localparam logic [7:0] OP_WAIT_FRAME = 8'h04;
    localparam logic [7:0] OP_IRQ        = 8'h07;
    localparam logic [7:0] OP_INDEXED    = 8'h09;

    typedef enum logic [2:0] {
        K_WRITE    = 3'd0,
        K_NOOP     = 3'd1,
        K_WAIT_US  = 3'd2,
        K_WAIT_FR  = 3'd3,
        K_IRQ      = 3'd4,
        K_FINISH   = 3'd5
    } req_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_EMIT_LO,
        S_EMIT_HI,
        S_CONV_HDR,
        S_CONV_MOVE,
        S_APPEND,
        S_COUNT,
        S_PAD,
        S_FILL,
        S_DONE
    } pk_state_e;

    function automatic logic [3:0] mask_to_be(input logic [31:0] mask);
        logic [3:0] be;
        for (int i = 0; i < 4; i++) begin
            be[i] = |mask[8*i +: 8];
        end
        return be;
    endfunction

endpackage

// File: rtl/cmdbuf_word_build.sv
module cmdbuf_word_build
    import cmdbuf_pkg::*;
(
    input  req_kind_e          kind,
    input  logic [OFF_W-1:0]   offset,
    input  logic [31:0]        value,
    input  logic [31:0]        mask,
    output logic [31:0]        lo_word,
    output logic [31:0]        hi_word,
    output logic               full_write
);

    logic [3:0] be;

    always_comb begin
        be         = mask_to_be(mask);
        full_write = 1'b0;
        lo_word    = 32'h0;
        hi_word    = {OP_NOOP, 24'h0};
        unique case (kind)
            K_WRITE: begin
                lo_word    = value;
                hi_word    = {OP_WRITE, be, offset};
                full_write = (be == 4'hF);
            end
            K_WAIT_US: begin
                lo_word = value;
                hi_word = {OP_WAIT_US, 24'h0};
            end
            K_WAIT_FR: begin
                lo_word = value;
                hi_word = {OP_WAIT_FRAME, 24'h0};
            end
            K_IRQ: begin
                hi_word = {OP_IRQ, 24'h0};
            end
            K_NOOP, K_FINISH: begin
                hi_word = {OP_NOOP, 24'h0};
            end
            default: begin
                hi_word = {OP_NOOP, 24'h0};
            end
        endcase
    end

endmodule

// File: rtl/cmdbuf_merge_check.sv
module cmdbuf_merge_check
    import cmdbuf_pkg::*;
(
    input  logic [31:0]        prev_hdr,
    input  logic               prev_present,
    input  logic [OFF_W-1:0]   offset,
    input  logic               full_write,
    output logic               do_convert,
    output logic               do_append
);

    logic eligible;

    always_comb begin
        eligible   = prev_present && full_write;
        do_convert = eligible && (prev_hdr == {OP_WRITE, 4'hF, offset});
        do_append  = eligible && (prev_hdr == {OP_INDEXED, 4'h0, offset});
    end

endmodule

// File: rtl/cmdbuf_packer.sv
module cmdbuf_packer
    import cmdbuf_pkg::*;
#(
    parameter int CAP_WORDS  = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [2:0]                     req_kind,
    input  logic [19:0]                    req_offset,
    input  logic [31:0]                    req_value,
    input  logic [31:0]                    req_mask,
    output logic                           overflow,
    output logic                           mem_we,
    output logic [$clog2(CAP_WORDS)-1:0]   mem_addr,
    output logic [31:0]                    mem_wdata,
    output logic                           tail_valid,
    output logic [$clog2(CAP_WORDS+1)+1:0] tail_bytes
);

    localparam int AW         = $clog2(CAP_WORDS);
    localparam int PTR_W      = $clog2(CAP_WORDS + 1);
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int LW         = $clog2(LINE_WORDS);
    localparam int BYTE_LW    = $clog2(LINE_BYTES);
    localparam logic [PTR_W-1:0] ROOM_LIMIT = PTR_W'(CAP_WORDS - 2);

    pk_state_e         state_q, state_d;
    logic [PTR_W-1:0]  ptr_q, start_q;
    logic [31:0]       ins_lo_q, ins_hi_q;
    logic [31:0]       rq_lo_q, rq_hi_q;

    req_kind_e         kind;
    logic [31:0]       lo_word, hi_word;
    logic              full_write;
    logic              do_convert, do_append;
    logic              room, accept, is_finish, take_emit;
    logic [PTR_W-1:0]  ptr_even;

    assign kind = req_kind_e'(req_kind);

    cmdbuf_word_build u_build (
        .kind       (kind),
        .offset     (req_offset),
        .value      (req_value),
        .mask       (req_mask),
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .full_write (full_write)
    );

    cmdbuf_merge_check u_merge (
        .prev_hdr     (ins_hi_q),
        .prev_present (ptr_q != '0),
        .offset       (req_offset),
        .full_write   (full_write),
        .do_convert   (do_convert),
        .do_append    (do_append)
    );

    always_comb begin
        room      = (ptr_q <= ROOM_LIMIT);
        accept    = (state_q == S_IDLE) && req_valid;
        is_finish = (kind == K_FINISH);
        take_emit = accept && !is_finish && room && !do_convert && !do_append;
        ptr_even  = ptr_q + {{(PTR_W-1){1'b0}}, ptr_q[0]};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (is_finish)
                        state_d = (ptr_q[LW-1:0] == '0) ? S_DONE : S_FILL;
                    else if (!room)
                        state_d = S_IDLE;
                    else if (do_convert)
                        state_d = S_CONV_HDR;
                    else if (do_append)
                        state_d = S_APPEND;
                    else
                        state_d = S_EMIT_LO;
                end
            end
            S_EMIT_LO:   state_d = S_EMIT_HI;
            S_EMIT_HI:   state_d = S_IDLE;
            S_CONV_HDR:  state_d = S_CONV_MOVE;
            S_CONV_MOVE: state_d = S_APPEND;
            S_APPEND:    state_d = S_COUNT;
            S_COUNT:     state_d = ptr_q[0] ? S_PAD : S_IDLE;
            S_PAD:       state_d = S_IDLE;
            S_FILL:      state_d = (ptr_q[LW-1:0] == {LW{1'b1}}) ? S_DONE : S_FILL;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else if (clr)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            start_q  <= '0;
            ins_lo_q <= '0;
            ins_hi_q <= '0;
            rq_lo_q  <= '0;
            rq_hi_q  <= '0;
        end else if (clr) begin
            ptr_q    <= '0;
            start_q  <= '0;
            ins_lo_q <= '0;
            ins_hi_q <= '0;
        end else begin
            if (accept) begin
                rq_lo_q <= lo_word;
                rq_hi_q <= hi_word;
            end
            if (take_emit)
                start_q <= ptr_even;
            unique case (state_q)
                S_EMIT_HI: begin
                    ptr_q    <= start_q + PTR_W'(2);
                    ins_lo_q <= rq_lo_q;
                    ins_hi_q <= rq_hi_q;
                end
                S_CONV_HDR: begin
                    ins_hi_q <= {OP_INDEXED, 4'h0, rq_hi_q[OFF_W-1:0]};
                end
                S_CONV_MOVE: begin
                    ins_lo_q <= 32'd1;
                    ptr_q    <= start_q + PTR_W'(3);
                end
                S_APPEND: begin
                    ptr_q    <= ptr_q + PTR_W'(1);
                    ins_lo_q <= ins_lo_q + 32'd1;
                end
                S_FILL: begin
                    ptr_q <= ptr_q + PTR_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        overflow   = accept && !is_finish && !room;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tail_valid = 1'b0;
        tail_bytes = {ptr_q, 2'b00};
        unique case (state_q)
            S_EMIT_LO: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(start_q);
                mem_wdata = rq_lo_q;
            end
            S_EMIT_HI: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(start_q + PTR_W'(1));
                mem_wdata = rq_hi_q;
            end
            S_CONV_HDR: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(start_q + PTR_W'(1));
                mem_wdata = {OP_INDEXED, 4'h0, rq_hi_q[OFF_W-1:0]};
            end
            S_CONV_MOVE: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(start_q + PTR_W'(2));
                mem_wdata = ins_lo_q;
            end
            S_APPEND: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(ptr_q);
                mem_wdata = rq_lo_q;
            end
            S_COUNT: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(start_q);
                mem_wdata = ins_lo_q;
            end
            S_PAD, S_FILL: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(ptr_q);
                mem_wdata = 32'h0;
            end
            S_DONE: begin
                tail_valid = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R1: a freshly emitted instruction leaves the pointer even
    a_r1_even_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == S_EMIT_HI) |=> (ptr_q[0] == 1'b0));

    // R3: conversion moves the earlier value two words past the start
    a_r3_move_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == S_CONV_HDR) |=>
            (mem_we && mem_addr == AW'(start_q + PTR_W'(2))));

    // R4: every append is followed by the count rewrite at the start
    a_r4_count_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == S_APPEND) |=> (mem_we && mem_addr == AW'(start_q)));

    // R5: odd pointer after an append gets a zero word
    a_r5_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state_q == S_COUNT && ptr_q[0]) |=>
            (mem_we && mem_wdata == 32'h0 && $stable(ptr_q)));

    // R7: a dropped request writes nothing and leaves the pointer alone
    a_r7_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> (!mem_we && $stable(ptr_q)));

    // R7: the pointer never passes capacity
    a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(CAP_WORDS));

    // R8: reported tail is line aligned
    a_r8_tail_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> (tail_bytes[BYTE_LW-1:0] == '0));

endmodule

// File: tb/cmdbuf_packer_test.sv
`timescale 1ns/1ps
module cmdbuf_packer_test;

    localparam int CAP = 64;

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] off;
        logic [31:0] val;
        logic [31:0] mask;
    } stim_t;

    localparam int NSTIM = 14;
    localparam stim_t STIM [NSTIM] = '{
        '{3'd0, 20'h00100, 32'hA1A1A1A1, 32'hFFFFFFFF},
        '{3'd0, 20'h00100, 32'hA2A2A2A2, 32'hFFFFFFFF},
        '{3'd0, 20'h00100, 32'hA3A3A3A3, 32'hFFFFFFFF},
        '{3'd0, 20'h00200, 32'hB1B1B1B1, 32'h0000FF00},
        '{3'd0, 20'h00200, 32'hB2B2B2B2, 32'hFFFFFFFF},
        '{3'd2, 20'h00000, 32'h00000025, 32'h00000000},
        '{3'd4, 20'h00000, 32'h12345678, 32'h00000000},
        '{3'd0, 20'h00300, 32'hC1C1C1C1, 32'hFFFFFFFF},
        '{3'd0, 20'h00300, 32'hC2C2C2C2, 32'hFFFFFFFF},
        '{3'd0, 20'h00300, 32'hC3C3C3C3, 32'hFFFFFFFF},
        '{3'd0, 20'h00300, 32'hC4C4C4C4, 32'hFFFFFFFF},
        '{3'd1, 20'h00000, 32'h99999999, 32'h00000000},
        '{3'd3, 20'h00000, 32'h00000003, 32'h00000000},
        '{3'd5, 20'h00000, 32'h00000000, 32'h00000000}
    };

    localparam int NEXP = 32;
    localparam logic [31:0] EXP_MEM [NEXP] = '{
        32'h00000003,  // 0  R4 count 3
        32'h09000100,  // 1  R3 indexed header
        32'hA1A1A1A1,  // 2  R3 moved value
        32'hA2A2A2A2,  // 3  R4
        32'hA3A3A3A3,  // 4  R4
        32'h00000000,  // 5  R5 pad
        32'hB1B1B1B1,  // 6  R1 aligned from 5
        32'h01200200,  // 7  R6 partial enables
        32'hB2B2B2B2,  // 8  R6 not merged
        32'h01F00200,  // 9  R2 single header
        32'h00000025,  // 10 R10 wait us
        32'h02000000,  // 11 R10
        32'h00000000,  // 12 R10 irq lo
        32'h07000000,  // 13 R10 irq
        32'h00000004,  // 14 R4 count 4
        32'h09000300,  // 15 R3
        32'hC1C1C1C1,  // 16 R3
        32'hC2C2C2C2,  // 17 R4
        32'hC3C3C3C3,  // 18 R4
        32'hC4C4C4C4,  // 19 R4 overwrites pad
        32'h00000000,  // 20 R10 noop
        32'h00000000,  // 21 R10 noop
        32'h00000003,  // 22 R10 frame wait
        32'h04000000,  // 23 R10
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0  // 24..31 R8 fill
    };
    localparam int EXP_REQ [NEXP] = '{
        4, 3, 3, 4, 4, 5, 1, 6, 6, 2, 10, 10, 10, 10, 4, 3,
        3, 4, 4, 4, 10, 10, 10, 10, 8, 8, 8, 8, 8, 8, 8, 8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_value = '0;
    logic [31:0] req_mask = '0;
    logic        overflow;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        tail_valid;
    logic [8:0]  tail_bytes;

    always #2 clk = ~clk;

    cmdbuf_packer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_kind   (req_kind),
        .req_offset (req_offset),
        .req_value  (req_value),
        .req_mask   (req_mask),
        .overflow   (overflow),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .tail_valid (tail_valid),
        .tail_bytes (tail_bytes)
    );

    logic [31:0] mem [CAP];
    int          ovf_cnt = 0;
    int          wr_cnt = 0;
    logic        tail_seen = 1'b0;
    logic [8:0]  tail_got = '0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          ended = 1'b0;

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (overflow) ovf_cnt <= ovf_cnt + 1;
        if (tail_valid) begin
            tail_seen <= 1'b1;
            tail_got  <= tail_bytes;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic junk_fill();
        for (int i = 0; i < CAP; i++) mem[i] = 32'hDEAD0000 | i;
    endtask

    task automatic send(input logic [2:0] k, input logic [19:0] o,
                        input logic [31:0] v, input logic [31:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = k;
        req_offset = o;
        req_value  = v;
        req_mask   = m;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic do_finish(output logic [8:0] t);
        @(negedge clk);
        tail_seen = 1'b0;
        send(3'd5, '0, '0, '0);
        @(negedge clk);
        t = tail_seen ? tail_got : 9'h1FF;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [8:0] t;
        int ovf0, wr0;
        junk_fill();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(req_ready == 1'b1, "reset", {31'b0, req_ready}, 32'd1, "ready");
        check(overflow == 1'b0, "reset", {31'b0, overflow}, 32'd0, "overflow");
        check(mem_we == 1'b0, "reset", {31'b0, mem_we}, 32'd0, "mem_we");
        check(tail_valid == 1'b0, "reset", {31'b0, tail_valid}, 32'd0, "tail_valid");

        // table walk: R1 R2 R3 R4 R5 R6 R8 R10
        tail_seen = 1'b0;
        for (int i = 0; i < NSTIM; i++) begin
            send(STIM[i].kind, STIM[i].off, STIM[i].val, STIM[i].mask);
        end
        @(negedge clk);
        for (int i = 0; i < NEXP; i++) begin
            check(mem[i] == EXP_MEM[i], $sformatf("R%0d word %0d", EXP_REQ[i], i),
                  mem[i], EXP_MEM[i], "buffer");
        end
        check(tail_seen && tail_got == 9'd128, "R8", {23'b0, tail_got}, 32'd128, "tail after fill");

        // R9 R11: clear drops the saved instruction, no merge follows
        do_clear();
        send(3'd0, 20'h00500, 32'h11111111, 32'hFFFFFFFF);
        do_clear();
        junk_fill();
        send(3'd0, 20'h00500, 32'h22222222, 32'hFFFFFFFF);
        @(negedge clk);
        check(mem[0] == 32'h22222222, "R9", mem[0], 32'h22222222, "value at 0");
        check(mem[1] == 32'h01F00500, "R11", mem[1], 32'h01F00500, "header not converted");
        check(mem[2] == 32'hDEAD0002, "R11", mem[2], 32'hDEAD0002, "no moved value");
        do_finish(t);
        check(t == 9'd64, "R8", {23'b0, t}, 32'd64, "tail from pointer 2");

        // R6: enables from a sparse mask, then no merge
        do_clear();
        send(3'd0, 20'h00010, 32'h55555555, 32'hFF000001);
        send(3'd0, 20'h00010, 32'h66666666, 32'hFFFFFFFF);
        @(negedge clk);
        check(mem[1] == 32'h01900010, "R6", mem[1], 32'h01900010, "sparse enables");
        check(mem[3] == 32'h01F00010, "R6", mem[3], 32'h01F00010, "partial never merged");

        // R8: finish at pointer zero writes nothing
        do_clear();
        wr0 = wr_cnt;
        do_finish(t);
        check(t == 9'd0, "R8", {23'b0, t}, 32'd0, "tail at zero");
        check(wr_cnt == wr0, "R8", wr_cnt, wr0, "no fill writes when aligned");

        // R7: overflow on a merge and on a fresh instruction
        do_clear();
        for (int i = 0; i < 31; i++) send(3'd1, '0, '0, '0);
        send(3'd0, 20'h00700, 32'hE1E1E1E1, 32'hFFFFFFFF);
        ovf0 = ovf_cnt;
        wr0  = wr_cnt;
        send(3'd0, 20'h00700, 32'hE2E2E2E2, 32'hFFFFFFFF);
        @(negedge clk);
        check(ovf_cnt == ovf0 + 1, "R7", ovf_cnt, ovf0 + 1, "overflow on merge");
        check(wr_cnt == wr0, "R7", wr_cnt, wr0, "no write on drop");
        check(mem[63] == 32'h01F00700, "R7", mem[63], 32'h01F00700, "header untouched");
        check(mem[62] == 32'hE1E1E1E1, "R7", mem[62], 32'hE1E1E1E1, "value untouched");
        send(3'd1, '0, '0, '0);
        @(negedge clk);
        check(ovf_cnt == ovf0 + 2, "R7", ovf_cnt, ovf0 + 2, "overflow on no-op");
        do_finish(t);
        check(t == 9'd256, "R8", {23'b0, t}, 32'd256, "tail at capacity");

        summary();
    end

endmodule